// File: doc/BRIEF.md
# Cascaded Three-Byte Interval Timer

This block produces a repeating interval of a programmed number of ticks, where each tick is one cycle with the tick enable high. The count is given as one 24-bit word made of three bytes: high in bits 23:16, mid in bits 15:8 and low in bits 7:0. The block does not hold it as one wide down-counter.

The low byte sets the preload of an 8-bit up-counter. That counter starts at 256 minus the low byte, so its first rollover comes after exactly the low-byte number of ticks. After that it rolls over every 256 ticks. Each rollover decrements the mid byte. When the decremented mid byte becomes zero, the high byte is decremented. When the decremented high byte becomes zero, the interval has expired.

On expiry the block inverts its output bit and raises a one-cycle pulse. It reloads all three stages from the value captured at the last start, so the interval runs again without any outside action. A start strobe loads the stages and clears the output.

Top module: `cascade_interval_timer`

## Requirements
- R1: After reset, `tog_out` and `expire_pulse` are both 0.
- R2: With high = 1 and mid = 1, the interval is exactly `low` ticks, where low is bits 7:0 and takes a value from 1 to 255.
- R3: With high = 1 and mid = M, where M is bits 15:8 and M > 0, the interval is `low + 256*(M-1)` ticks.
- R4: When the mid byte reaches zero and the high byte does not, the mid byte continues from its wrapped value. With high = H, where H is bits 23:16, the interval is `low + 256*(M + 256*(H-1) - 1)` ticks.
- R5: On expiry, `tog_out` inverts and `expire_pulse` is 1 for one cycle. Both change on the same clock edge, which is the edge of the final tick.
- R6: After expiry, the counters reload by themselves, and the next interval has the same length.
- R7: `start` loads all stages and clears `tog_out`. When it falls on the same edge as a tick, or as an expiry, `start` wins: no tick is counted, no pulse is produced, and the full interval then begins again.
- R8: While `tick_en` is 0, the count holds, and neither `tog_out` nor `expire_pulse` changes.
- R9: `reload_val` is captured only by `start`. A change of `reload_val` afterwards has no effect on the interval length until the next start.
- R10: A zero byte counts as 256. A low byte of 0 gives a first rollover after 256 ticks, and a mid byte of 0 gives 256 rollovers before the high byte steps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reload_val | input | 24 | Interval bytes: high in 23:16, mid in 15:8, low in 7:0 |
| start | input | 1 | Load the stages from reload_val and clear the output |
| tick_en | input | 1 | Count one tick in this cycle |
| tog_out | output | 1 | Output bit that inverts on every expiry |
| expire_pulse | output | 1 | One-cycle pulse on expiry |

## Verification
The start strobe and the counting path can land on the same edge, including the edge that would expire the interval. The bench lets an interval run to one tick short of expiry. It then raises start and keeps tick_en high, so the final tick and the strobe share one edge. The result is judged correct when no pulse appears, the output reads 0, and a full interval is needed before the next expiry.

// File: rtl/cascade_interval_timer.sv
module cascade_interval_timer #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [3*BYTE_W-1:0] reload_val,
  input  logic                start,
  input  logic                tick_en,
  output logic                tog_out,
  output logic                expire_pulse
);
  localparam int CNT_W = 3 * BYTE_W;

  logic [CNT_W-1:0]  rld_q;
  logic [BYTE_W-1:0] lo_q, mid_q, hi_q;
  logic              tog_q, pulse_q;

  logic [BYTE_W-1:0] mid_dec, hi_dec;
  logic              lo_wrap, mid_done, hi_done;

  assign mid_dec  = mid_q - 1'b1;
  assign hi_dec   = hi_q - 1'b1;
  assign lo_wrap  = tick_en && (lo_q == {BYTE_W{1'b1}});
  assign mid_done = (mid_dec == '0);
  assign hi_done  = (hi_dec == '0);

  function automatic logic [BYTE_W-1:0] preload(input logic [CNT_W-1:0] v);
    return {BYTE_W{1'b0}} - v[BYTE_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rld_q   <= '0;
      lo_q    <= '0;
      mid_q   <= '0;
      hi_q    <= '0;
      tog_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (start) begin
        rld_q <= reload_val;
        lo_q  <= preload(reload_val);
        mid_q <= reload_val[2*BYTE_W-1:BYTE_W];
        hi_q  <= reload_val[CNT_W-1:2*BYTE_W];
        tog_q <= 1'b0;
      end else if (tick_en) begin
        lo_q <= lo_q + 1'b1;
        if (lo_wrap) begin
          mid_q <= mid_dec;
          if (mid_done) begin
            hi_q <= hi_dec;
            if (hi_done) begin
              lo_q    <= preload(rld_q);
              mid_q   <= rld_q[2*BYTE_W-1:BYTE_W];
              hi_q    <= rld_q[CNT_W-1:2*BYTE_W];
              tog_q   <= ~tog_q;
              pulse_q <= 1'b1;
            end
          end
        end
      end
    end
  end

  assign tog_out      = tog_q;
  assign expire_pulse = pulse_q;
endmodule

// File: rtl/cascade_interval_timer_chk.sv
module cascade_interval_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic tick_en,
  input logic tog_out,
  input logic expire_pulse
);
  p_pulse_toggles_r5: assert property (@(posedge clk) disable iff (!rst_n)
    expire_pulse |-> (tog_out != $past(tog_out)));

  p_tog_only_on_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!expire_pulse && !$past(start)) |-> $stable(tog_out));

  p_start_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!tog_out && !expire_pulse));

  p_hold_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !start) |=> (!expire_pulse && $stable(tog_out)));
endmodule

bind cascade_interval_timer cascade_interval_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .tick_en(tick_en),
  .tog_out(tog_out), .expire_pulse(expire_pulse)
);

// File: tb/cascade_interval_timer_bench.sv
module cascade_interval_timer_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] reload_val = '0;
  logic        start = 1'b0;
  logic        tick_en = 1'b0;
  logic        tog_out, expire_pulse;

  int n_chk = 0;
  int n_bad = 0;
  logic exp_tog = 1'b0;
  logic done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  cascade_interval_timer u_cascade_interval_timer (
    .clk(clk), .rst_n(rst_n), .reload_val(reload_val), .start(start),
    .tick_en(tick_en), .tog_out(tog_out), .expire_pulse(expire_pulse)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_start(input logic [23:0] v, input string req);
    @(negedge clk);
    reload_val = v;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    exp_tog = 1'b0;
    check(tog_out == 1'b0 && expire_pulse == 1'b0, req, {tog_out, expire_pulse}, 0);
  endtask

  // Ticks n cycles from a negedge, expecting expiry on the last one.
  task automatic run_interval(input int n, input string req);
    int early = 0;
    tick_en = 1'b1;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (i < n && expire_pulse) early++;
    end
    exp_tog = ~exp_tog;
    check(early == 0, req, early, 0);
    check(expire_pulse == 1'b1 && tog_out == exp_tog, req,
          {expire_pulse, tog_out}, {1'b1, exp_tog});
    tick_en = 1'b0;
    @(negedge clk);
    check(expire_pulse == 1'b0 && tog_out == exp_tog, "R5 single-cycle pulse",
          {expire_pulse, tog_out}, {1'b0, exp_tog});
  endtask

  task automatic t_reset();
    check(tog_out == 1'b0 && expire_pulse == 1'b0, "R1", {tog_out, expire_pulse}, 0);
  endtask

  task automatic t_low_only();
    do_start(24'h010105, "R7 start");
    run_interval(5, "R2 low byte interval");
    run_interval(5, "R6 reload repeat");
  endtask

  task automatic t_low_zero();
    do_start(24'h010100, "R7 start");
    run_interval(256, "R10 low byte zero");
  endtask

  task automatic t_mid();
    do_start(24'h010310, "R7 start");
    run_interval(16 + 256 * 2, "R3 mid byte interval");
    run_interval(16 + 256 * 2, "R6 reload repeat");
  endtask

  task automatic t_high();
    do_start(24'h020103, "R7 start");
    run_interval(3 + 256 * 256, "R4 high byte with mid wrap");
  endtask

  task automatic t_mid_zero();
    do_start(24'h010001, "R7 start");
    run_interval(1 + 255 * 256, "R10 mid byte zero");
  endtask

  task automatic t_pause();
    int bad = 0;
    do_start(24'h010108, "R7 start");
    tick_en = 1'b1;
    repeat (3) @(negedge clk);
    tick_en = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (expire_pulse || tog_out != exp_tog) bad++;
    end
    check(bad == 0, "R8 hold while disabled", bad, 0);
    run_interval(5, "R8 resume count");
  endtask

  task automatic t_capture();
    do_start(24'h010106, "R7 start");
    reload_val = 24'h010102;
    run_interval(6, "R9 captured value");
    run_interval(6, "R9 captured value on reload");
  endtask

  task automatic t_collide();
    do_start(24'h010105, "R7 start");
    run_interval(5, "R2 before collision");
    tick_en = 1'b1;
    repeat (4) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    exp_tog = 1'b0;
    check(expire_pulse == 1'b0 && tog_out == 1'b0, "R7 start beats expiry",
          {expire_pulse, tog_out}, 0);
    run_interval(5, "R7 full interval after collision");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_low_only();
    t_low_zero();
    t_mid();
    t_pause();
    t_capture();
    t_collide();
    t_high();
    t_mid_zero();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule